// File: doc/BRIEF.md
# Hardware Return Stack with Interrupt Acknowledge Gating

This block holds the return addresses of a small microcontroller core in a hidden eight-level stack that software can neither read nor write. A subroutine call pushes the current program counter together with the latched ROM bank-select bit. A return or a return-from-interrupt pops one frame and presents the saved address and bank bit to the fetch logic. After reset the stack is empty.

The same block decides when a pending interrupt may be taken. Each source has a request flag that a one-cycle event pulse sets. An acknowledge is issued only when the global enable is set, an enabled request is pending, no call or return is in progress, and a stack level is free. When the stack is full, the request flag is kept and the acknowledge waits until a return has freed a level. On acknowledge the block pushes the current program counter and bank bit, and outputs a fixed vector address for the winning source. The lowest source index has the highest priority.

A call issued into a full stack overwrites the oldest frame. It also sets a sticky overflow status bit that only reset clears.

Top module: `retstk_irq_ctrl`

## Requirements
- R1: After reset the stack is empty (`empty_o`=1, `full_o`=0), `ovf_o`=0, `gie_o`=0, no request is pending and `ack_o`=0.
- R2: A cycle with `call_i`=1 pushes `{bank_i, pc_i}`. Frames come back in last-in first-out order. `full_o` is 1 while eight frames are held.
- R3: During a cycle with `ret_i` or `reti_i` asserted, `ret_pc_o`/`ret_bank_o` show the most recently pushed frame, and that frame is removed at the clock edge. A return on an empty stack is ignored, and `empty_o` stays 1.
- R4: A call while eight frames are held overwrites the oldest frame, leaves the depth at eight, and sets `ovf_o`. `ovf_o` stays 1 until reset.
- R5: A 1 on `irq_i[i]` in one cycle sets request flag i. The flag stays set until that source is acknowledged.
- R6: `ack_o` is 1 only when all of these hold: `gie_o`=1; some pending source i has `irq_en_i[i]`=1; the stack is not full; and `call_i`, `ret_i`, `reti_i` are all 0. An acknowledge pushes `{bank_i, pc_i}`.
- R7: Among the acknowledgeable sources, the lowest index wins, and `vec_o` = 0x010 + 4*i: source 0 (timer 2) gives 0x010, source 1 (timer 3) gives 0x014, source 2 (D/A buffer empty) gives 0x018.
- R8: An acknowledge clears the winning request flag and `gie_o` from the next cycle on. `reti_i` or `ei_i` sets `gie_o` from the next cycle on.
- R9: A request held off by a full stack is acknowledged in the cycle after a return pops a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Subroutine call: push frame |
| ret_i | input | 1 | Return: pop frame |
| reti_i | input | 1 | Return from interrupt: pop frame, set global enable |
| ei_i | input | 1 | Set global interrupt enable |
| pc_i | input | 14 | Program counter to save |
| bank_i | input | 1 | Latched ROM bank bit to save |
| irq_i | input | 3 | Interrupt event pulses, one per source |
| irq_en_i | input | 3 | Per-source enable |
| ack_o | output | 1 | Interrupt acknowledge this cycle |
| vec_o | output | 14 | Vector address of the acknowledged source |
| ret_pc_o | output | 14 | Saved program counter of the top frame |
| ret_bank_o | output | 1 | Saved bank bit of the top frame |
| full_o | output | 1 | Eight frames held |
| empty_o | output | 1 | No frame held |
| ovf_o | output | 1 | Sticky overflow: a call wrapped the stack |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The assertions check on every cycle that the depth never exceeds eight and moves by one on each push or pop. They also check that no acknowledge occurs while the stack is full, that the grant is at most one-hot, that the global enable drops after each acknowledge, and that the overflow bit never clears. Only the bench's scenarios show the contents that come back: the last-in first-out order of the frames, which frame a wrapping call loses, the vector chosen when several sources are pending, and a request held off at full being serviced right after a return.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
    localparam int unsigned PC_W = 14;

    typedef struct packed {
        logic            bank;
        logic [PC_W-1:0] pc;
    } frame_t;
endpackage

// File: rtl/retstk_lifo.sv
module retstk_lifo
    import retstk_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  frame_t push_frame,
    output frame_t top_frame,
    output logic   full,
    output logic   empty,
    output logic   ovf
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

    typedef struct {
        frame_t           mem [DEPTH];
        logic [PTR_W-1:0] sp;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } st_t;

    st_t s_d, s_q;
    logic [PTR_W-1:0] sp_prev;

    always_comb begin
        sp_prev = (s_q.sp == '0) ? LAST : s_q.sp - 1'b1;
        s_d     = s_q;
        if (push) begin
            s_d.mem[s_q.sp] = push_frame;
            s_d.sp          = (s_q.sp == LAST) ? '0 : s_q.sp + 1'b1;
            if (s_q.cnt == CMAX) s_d.ovf = 1'b1;
            else                 s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && s_q.cnt != '0) begin
            s_d.sp  = sp_prev;
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sp  <= '0;
            s_q.cnt <= '0;
            s_q.ovf <= 1'b0;
        end else begin
            s_q.sp  <= s_d.sp;
            s_q.cnt <= s_d.cnt;
            s_q.ovf <= s_d.ovf;
        end
        s_q.mem <= s_d.mem;
    end

    assign top_frame = s_q.mem[sp_prev];
    assign full      = (s_q.cnt == CMAX);
    assign empty     = (s_q.cnt == '0);
    assign ovf       = s_q.ovf;

    // R2: depth bounded by the stack size
    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CMAX);
    // R2: a push into a non-full stack grows it by one
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && s_q.cnt < CMAX) |=> s_q.cnt == $past(s_q.cnt) + 1'b1);
    // R3: a pop without push on a non-empty stack shrinks it by one
    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.cnt != '0) |=> s_q.cnt == $past(s_q.cnt) - 1'b1);
    // R4: overflow status is sticky
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |=> s_q.ovf);
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int unsigned NSRC     = 3,
    parameter int unsigned PC_W     = 14,
    parameter int unsigned VEC_BASE = 16,
    parameter int unsigned VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] en,
    input  logic            set_gie,
    input  logic            busy,
    input  logic            stk_full,
    output logic            ack,
    output logic [PC_W-1:0] vec,
    output logic            gie
);
    localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0] flags;
        logic            gie;
    } st_t;

    st_t s_d, s_q;
    logic [NSRC-1:0]  cand, grant;
    logic [IDX_W-1:0] idx;

    always_comb begin
        cand = s_q.flags & en;
        idx  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
        grant = (cand != '0) ? (NSRC'(1) << idx) : '0;
        ack   = s_q.gie && (cand != '0) && !stk_full && !busy;
        vec   = PC_W'(VEC_BASE) + PC_W'(idx) * PC_W'(VEC_STEP);

        s_d       = s_q;
        s_d.flags = (s_q.flags & ~(ack ? grant : '0)) | raw;
        if (ack)          s_d.gie = 1'b0;
        else if (set_gie) s_d.gie = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gie = s_q.gie;

    // R7: at most one source is granted
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8: acknowledge drops the global enable
    a_r8_gie_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !s_q.gie);
endmodule

// File: rtl/retstk_irq_ctrl.sv
module retstk_irq_ctrl
    import retstk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            reti_i,
    input  logic            ei_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            bank_i,
    input  logic [2:0]      irq_i,
    input  logic [2:0]      irq_en_i,
    output logic            ack_o,
    output logic [PC_W-1:0] vec_o,
    output logic [PC_W-1:0] ret_pc_o,
    output logic            ret_bank_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            ovf_o,
    output logic            gie_o
);
    localparam int unsigned DEPTH = 8;
    localparam int unsigned NSRC  = 3;

    logic   busy, push, pop;
    frame_t top_frame, in_frame;

    assign busy     = call_i | ret_i | reti_i;
    assign push     = call_i | ack_o;
    assign pop      = (ret_i | reti_i) & ~call_i;
    assign in_frame = '{bank: bank_i, pc: pc_i};

    retstk_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_frame (in_frame),
        .top_frame  (top_frame),
        .full       (full_o),
        .empty      (empty_o),
        .ovf        (ovf_o)
    );

    irq_gate #(.NSRC(NSRC), .PC_W(PC_W), .VEC_BASE(16), .VEC_STEP(4)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (irq_i),
        .en       (irq_en_i),
        .set_gie  (reti_i | ei_i),
        .busy     (busy),
        .stk_full (full_o),
        .ack      (ack_o),
        .vec      (vec_o),
        .gie      (gie_o)
    );

    assign ret_pc_o   = top_frame.pc;
    assign ret_bank_o = top_frame.bank;

    // R6: no acknowledge while the stack is full
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !ack_o);
    // R6: no acknowledge in a call or return cycle
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i || ret_i || reti_i) |-> !ack_o);
endmodule

// File: tb/retstk_irq_ctrl_test.sv
module retstk_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, reti_i = 0, ei_i = 0, bank_i = 0;
    logic [13:0] pc_i = '0;
    logic [2:0]  irq_i = '0, irq_en_i = '0;
    logic        ack_o, ret_bank_o, full_o, empty_o, ovf_o, gie_o;
    logic [13:0] vec_o, ret_pc_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    retstk_irq_ctrl uut (.*);

    typedef struct packed {
        logic [1:0]  op;     // 1 call, 2 ret
        logic [13:0] pc;
        logic        bank;
        logic        chk;
        logic [13:0] epc;
        logic        ebank;
        logic        efull;
        logic        eempty;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 14'h100, 1'b0, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h101, 1'b1, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h102, 1'b0, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h103, 1'b1, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h104, 1'b0, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h105, 1'b1, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h106, 1'b0, 1'b0, 14'h0,   1'b0, 1'b0, 1'b0},
        '{2'd1, 14'h107, 1'b1, 1'b0, 14'h0,   1'b0, 1'b1, 1'b0},
        '{2'd1, 14'h108, 1'b0, 1'b0, 14'h0,   1'b0, 1'b1, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h108, 1'b0, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h107, 1'b1, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h106, 1'b0, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h105, 1'b1, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h104, 1'b0, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h103, 1'b1, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h102, 1'b0, 1'b0, 1'b0},
        '{2'd2, 14'h0,   1'b0, 1'b1, 14'h101, 1'b1, 1'b0, 1'b1},
        '{2'd2, 14'h0,   1'b0, 1'b0, 14'h0,   1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1 empty", int'(empty_o), 1);
        check("R1 full", int'(full_o), 0);
        check("R1 ovf", int'(ovf_o), 0);
        check("R1 gie", int'(gie_o), 0);
        check("R1 ack", int'(ack_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4: vector table of pushes and pops
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            call_i = (TBL[k].op == 2'd1);
            ret_i  = (TBL[k].op == 2'd2);
            pc_i   = TBL[k].pc;
            bank_i = TBL[k].bank;
            #1;
            if (TBL[k].chk) begin
                check("R2 R3 ret_pc", int'(ret_pc_o), int'(TBL[k].epc));
                check("R2 R3 ret_bank", int'(ret_bank_o), int'(TBL[k].ebank));
            end
            @(negedge clk);
            call_i = 0; ret_i = 0;
            #1;
            check("R2 full", int'(full_o), int'(TBL[k].efull));
            check("R3 empty", int'(empty_o), int'(TBL[k].eempty));
        end
        check("R4 ovf set", int'(ovf_o), 1);

        // R7 R8: two pending sources, priority and vector
        @(negedge clk);
        ei_i = 1; irq_i = 3'b110; irq_en_i = 3'b111; pc_i = 14'h200; bank_i = 1;
        #1;
        check("R6 no ack gie off", int'(ack_o), 0);
        @(negedge clk);
        ei_i = 0; irq_i = '0;
        #1;
        check("R8 ei sets gie", int'(gie_o), 1);
        check("R7 ack", int'(ack_o), 1);
        check("R7 vec src1", int'(vec_o), 'h14);
        @(negedge clk);
        #1;
        check("R8 gie cleared", int'(gie_o), 0);
        check("R6 ack held gie off", int'(ack_o), 0);
        reti_i = 1;
        #1;
        check("R6 ack frame pc", int'(ret_pc_o), 'h200);
        check("R6 ack frame bank", int'(ret_bank_o), 1);
        @(negedge clk);
        reti_i = 0;
        #1;
        check("R8 reti sets gie", int'(gie_o), 1);
        check("R5 flag kept ack", int'(ack_o), 1);
        check("R7 vec src2", int'(vec_o), 'h18);
        @(negedge clk);
        reti_i = 1;
        @(negedge clk);
        reti_i = 0;
        #1;
        check("R3 empty after reti", int'(empty_o), 1);

        // R6: disabled source is not acknowledged
        irq_en_i = 3'b110; irq_i = 3'b001;
        @(negedge clk);
        irq_i = '0;
        #1;
        check("R6 disabled src", int'(ack_o), 0);
        irq_en_i = 3'b111;
        #1;
        check("R7 ack src0", int'(ack_o), 1);
        check("R7 vec src0", int'(vec_o), 'h10);
        @(negedge clk);
        reti_i = 1;
        @(negedge clk);
        reti_i = 0;
        irq_en_i = '0;

        // R9: request held off by a full stack
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            call_i = 1; pc_i = 14'h300 + 14'(k); bank_i = 1'(k);
            @(negedge clk);
            call_i = 0;
        end
        #1;
        check("R2 full after eight", int'(full_o), 1);
        irq_i = 3'b001; irq_en_i = 3'b001;
        @(negedge clk);
        irq_i = '0;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R6 full blocks ack", int'(ack_o), 0);
            @(negedge clk);
        end
        ret_i = 1;
        #1;
        check("R6 ret cycle blocks ack", int'(ack_o), 0);
        check("R3 ret_pc", int'(ret_pc_o), 'h307);
        @(negedge clk);
        ret_i = 0;
        #1;
        check("R9 ack after pop", int'(ack_o), 1);
        check("R9 vec", int'(vec_o), 'h10);
        @(negedge clk);
        #1;
        check("R9 full again", int'(full_o), 1);
        check("R4 ovf sticky", int'(ovf_o), 1);
        finish_run();
    end
endmodule